// File: doc/BRIEF.md
# MDIO Management Master

This block runs register read and write transactions to an external Ethernet PHY over the two-wire management interface. It derives the management clock MDC from a faster system clock. The high phase, the low phase and the whole period of MDC each meet a minimum length in nanoseconds, whatever the system clock period is. MDC is held low and stops between transactions.

A host starts a transaction by raising `req_valid` for one cycle while `busy` is low. With it the host gives a read/write select, a PHY address, a register address and write data. The master then shifts out one frame. On the bus side the master changes its output only when MDC falls, and it samples the PHY only when MDC rises. During a read it releases the data line for the turnaround and data bits. At the end it pulses `done` for one cycle and, after a read, presents the captured 16-bit value on `rdata`.

Top module: `mdio_master`

## Requirements
- R1: Every MDC high phase lasts at least 160 ns (8 cycles of the 20 ns default system clock).
- R2: Every MDC low phase lasts at least 160 ns.
- R3: Every MDC period, meaning a high phase plus the low phase that follows it, lasts at least 400 ns.
- R4: A write frame carries 64 bits, MSB first, sampled on MDC rising edges, in this order: 32 ones, start bits 0 then 1, op bits 0 then 1, 5-bit PHY address, 5-bit register address, turnaround bits 1 then 0, and 16 write-data bits.
- R5: A read frame carries op bits 1 then 0. The master drives (`mdio_oe`=1) only the first 46 bits, then releases the line for the turnaround and the 16 data bits. The 16 bits sampled on the last 16 MDC rising edges appear on `rdata`, first bit as MSB, in the cycle that `done` is high. `rdata` holds its value across write frames.
- R6: `mdio_o` and `mdio_oe` never change while MDC is high.
- R7: `busy` is high from the cycle after an accepted request until the end of the frame. A request made while `busy` is high is ignored and does not alter the frame in progress.
- R8: `done` is high for exactly one cycle per frame. In that cycle `busy` is already low.
- R9: While no frame is in progress, MDC stays low and `mdio_oe` stays low.
- R10: During and just after reset, `mdc`, `mdio_oe`, `busy`, `done` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transaction (taken only when not busy) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (0 = released) |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench runs writes and reads against a small PHY model that drives the turnaround zero and the data bits on MDC falling edges. The fields are all-zero, all-one and random, so a swapped, shifted or truncated field shows up in the bit string recorded at the rising edges. Reads returning 0x0001 and 0x8000 separate the MSB-first capture from an LSB-first one, and they expose an off-by-one in the sampling window. A request made in the middle of a frame, with every field inverted, separates a master that ignores requests while busy from one that restarts or latches the new request. The MDC phase lengths are measured over all frames and compared with the nanosecond minimums.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mdio_op_e;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] TA_DRIVEN  = 2'b10;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
   parameter int HI_CYC = 10,
   parameter int LO_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_now,
   output logic fall_now
);
   localparam int CNT_W = $clog2(mdio_pkg::max_int(HI_CYC, LO_CYC) + 1);

   logic [CNT_W-1:0] cnt;
   logic             term;

   generate
      if (HI_CYC == LO_CYC) begin : g_sym
         assign term = (cnt == CNT_W'(HI_CYC - 1));
      end else begin : g_asym
         assign term = mdc ? (cnt == CNT_W'(HI_CYC - 1))
                           : (cnt == CNT_W'(LO_CYC - 1));
      end
      if (HI_CYC < 1 || LO_CYC < 1) begin : g_bad_phase
         initial $fatal(1, "mdc_gen: phase length must be at least one cycle");
      end
   endgenerate

   assign rise_now = run & ~mdc & term;
   assign fall_now = run &  mdc & term;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (term) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              bit_in,
   input  logic              commit,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rx_sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_sh <= '0;
         rdata <= '0;
      end else begin
         if (sample_en) rx_sh <= {rx_sh[DATA_W-2:0], bit_in};
         if (commit)    rdata <= rx_sh;
      end
   end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
   parameter int PRE_LEN = 32,
   parameter int PHY_W   = 5,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [PHY_W-1:0]  req_phy,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              rise_now,
   input  logic              fall_now,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rdata
);
   import mdio_pkg::*;

   localparam int HDR_BITS   = PRE_LEN + 4 + PHY_W + REG_W;
   localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] tx_sh;
   logic [IDX_W-1:0]      idx;
   logic                  rd_q;
   logic                  last_bit;
   mdio_op_e              op;

   assign op       = req_read ? OP_READ : OP_WRITE;
   assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         rd_q  <= 1'b0;
         idx   <= '0;
         tx_sh <= '0;
      end else begin
         done <= 1'b0;
         if (!busy && req_valid) begin
            busy  <= 1'b1;
            rd_q  <= req_read;
            idx   <= '0;
            tx_sh <= {{PRE_LEN{1'b1}}, START_CODE, op, req_phy, req_reg,
                      TA_DRIVEN, req_read ? {DATA_W{1'b0}} : req_wdata};
         end else if (busy && fall_now) begin
            if (last_bit) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               idx   <= idx + 1'b1;
               tx_sh <= tx_sh << 1;
            end
         end
      end
   end

   assign mdio_o  = busy & tx_sh[FRAME_BITS-1];
   assign mdio_oe = busy & (~rd_q | (idx < IDX_W'(HDR_BITS)));

   mdio_rx_capture #(.DATA_W(DATA_W)) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (busy & rise_now & rd_q & (idx >= IDX_W'(HDR_BITS + 2))),
      .bit_in    (mdio_i),
      .commit    (busy & fall_now & last_bit & rd_q),
      .rdata     (rdata)
   );

   generate
      if (DATA_W < 2 || PHY_W < 1 || REG_W < 1 || PRE_LEN < 1) begin : g_bad_field
         initial $fatal(1, "mdio_seq: field widths out of range");
      end
   endgenerate

   // done and busy hand over in the same cycle
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));                                   // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R8

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int CLK_PERIOD_PS = 20000,
   parameter int MIN_HIGH_NS   = 160,
   parameter int MIN_LOW_NS    = 160,
   parameter int MIN_PERIOD_NS = 400,
   parameter int PRE_LEN       = 32,
   parameter int PHY_W         = 5,
   parameter int REG_W         = 5,
   parameter int DATA_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [PHY_W-1:0]  req_phy,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   import mdio_pkg::*;

   localparam int HI_MIN  = ceil_div(MIN_HIGH_NS * 1000, CLK_PERIOD_PS);
   localparam int LO_MIN  = ceil_div(MIN_LOW_NS * 1000, CLK_PERIOD_PS);
   localparam int PER_MIN = ceil_div(MIN_PERIOD_NS * 1000, CLK_PERIOD_PS);
   localparam int HI_CYC  = max_int(HI_MIN, ceil_div(PER_MIN, 2));
   localparam int LO_CYC  = max_int(LO_MIN, PER_MIN - HI_CYC);
   localparam int MON_W   = $clog2(HI_CYC + LO_CYC + 1) + 1;

   generate
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         initial $fatal(1, "mdio_master: clock period must be positive");
      end
   endgenerate

   logic rise_now, fall_now;

   mdc_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) i_mdc_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   mdio_seq #(
      .PRE_LEN (PRE_LEN),
      .PHY_W   (PHY_W),
      .REG_W   (REG_W),
      .DATA_W  (DATA_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_read  (req_read),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_wdata (req_wdata),
      .rise_now  (rise_now),
      .fall_now  (fall_now),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .done      (done),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rdata     (rdata)
   );

   // phase-length monitors for the timing assertions
   logic             mdc_d;
   logic [MON_W-1:0] hi_len, lo_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_d  <= 1'b0;
         hi_len <= '0;
         lo_len <= '0;
      end else begin
         mdc_d <= mdc;
         if (mdc && !mdc_d)           hi_len <= MON_W'(1);
         else if (mdc && hi_len != '1) hi_len <= hi_len + 1'b1;
         if (!mdc && mdc_d)           lo_len <= MON_W'(1);
         else if (!mdc && lo_len != '1) lo_len <= lo_len + 1'b1;
      end
   end

   AST_MDC_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (32'(hi_len) >= HI_MIN));                            // R1
   AST_MDC_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> (32'(lo_len) >= LO_MIN));                            // R2
   AST_MDC_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mdc) && hi_len != '0) |-> (32'(hi_len) + 32'(lo_len) >= PER_MIN)); // R3
   AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));                     // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));                                      // R9

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, req_valid, req_read;
   logic [4:0]  req_phy, req_reg;
   logic [15:0] req_wdata;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic [15:0] rdata;
   logic        phy_en, phy_val, line;

   assign line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

   mdio_master i_mdio_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
   );

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
         input logic [4:0] r, input logic [15:0] wd, input logic [15:0] rv);
      return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, rd ? rv : wd};
   endfunction

   function automatic logic [63:0] exp_oe(input bit rd);
      return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
   endfunction

   // bus monitor and PHY model, sampled on the falling system clock edge
   bit          cur_rd;
   logic [15:0] cur_data;
   logic [63:0] rec_frame, rec_oe;
   int rise_cnt, hi_run, lo_run, last_hi, chg_hi;
   int min_hi = 1000, min_lo = 1000, min_per = 1000;
   logic prev_mdc, prev_o, prev_oe, prev_busy;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_mdc = 0; prev_o = 0; prev_oe = 0; prev_busy = 0;
         hi_run = 0; lo_run = 0; last_hi = 0; rise_cnt = 0; chg_hi = 0;
         phy_en = 0; phy_val = 1;
      end else begin
         if (busy && !prev_busy) rise_cnt = 0;
         if (mdc && !prev_mdc) begin
            if (lo_run < min_lo) min_lo = lo_run;
            if (last_hi > 0 && last_hi + lo_run < min_per) min_per = last_hi + lo_run;
            rec_frame = {rec_frame[62:0], line};
            rec_oe    = {rec_oe[62:0], mdio_oe};
            rise_cnt++;
            hi_run = 1;
         end else if (mdc) hi_run++;
         if (!mdc && prev_mdc) begin
            if (hi_run < min_hi) min_hi = hi_run;
            last_hi = hi_run;
            lo_run = 1;
            if (cur_rd && rise_cnt == 47) begin phy_en = 1; phy_val = 0; end
            else if (cur_rd && rise_cnt >= 48 && rise_cnt < 64) begin
               phy_en = 1; phy_val = cur_data[63 - rise_cnt];
            end else phy_en = 0;
         end else if (!mdc) lo_run++;
         if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) chg_hi++;
         prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_busy = busy;
      end
   end

   task automatic txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] wd, input logic [15:0] rv, input bit poke);
      int n;
      int idle_bad;
      logic [15:0] old_rdata;
      old_rdata = rdata;
      cur_rd = rd; cur_data = rv;
      @(negedge clk);
      req_valid = 1; req_read = rd; req_phy = p; req_reg = r; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      req_read = ~rd; req_phy = ~p; req_reg = ~r; req_wdata = ~wd;
      chk(busy === 1'b1, "R7", "busy after request", 64'(busy), 64'd1);
      n = 0;
      while (done !== 1'b1 && n < 3000) begin
         req_valid = (poke && n == 400);  // R7: request while busy
         @(negedge clk);
         n++;
      end
      req_valid = 0;
      chk(done === 1'b1, "R8", "done reached", 64'(done), 64'd1);
      chk(busy === 1'b0, "R8", "busy low with done", 64'(busy), 64'd0);
      chk(rec_frame === exp_frame(rd, p, r, wd, rv), rd ? "R5" : "R4",
          "frame bits", rec_frame, exp_frame(rd, p, r, wd, rv));
      chk(rec_oe === exp_oe(rd), rd ? "R5" : "R4", "drive mask", rec_oe, exp_oe(rd));
      if (rd) chk(rdata === rv, "R5", "read data", 64'(rdata), 64'(rv));
      else    chk(rdata === old_rdata, "R5", "rdata held on write", 64'(rdata), 64'(old_rdata));
      @(negedge clk);
      chk(done === 1'b0, "R8", "done one cycle", 64'(done), 64'd0);
      idle_bad = 0;
      for (int k = 0; k < 30; k++) begin
         if (mdc !== 1'b0 || mdio_oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0) idle_bad++;
         @(negedge clk);
      end
      chk(idle_bad == 0, poke ? "R7" : "R9", "idle quiet after frame", 64'(idle_bad), 64'd0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 0; req_valid = 0; req_read = 0; req_phy = 0; req_reg = 0; req_wdata = 0;
      cur_rd = 0; cur_data = 0; rec_frame = 0; rec_oe = 0;
      repeat (4) @(negedge clk);
      chk({mdc, mdio_oe, busy, done} === 4'b0, "R10", "outputs in reset",
          64'({mdc, mdio_oe, busy, done}), 64'd0);
      chk(rdata === 16'h0, "R10", "rdata in reset", 64'(rdata), 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk({mdc, mdio_oe, busy, done} === 4'b0, "R10", "outputs after reset",
          64'({mdc, mdio_oe, busy, done}), 64'd0);
      // directed corners
      txn(0, 5'h00, 5'h00, 16'h0000, 16'h0, 0);
      txn(0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 0);
      txn(1, 5'h01, 5'h10, 16'h0, 16'h0001, 0);
      txn(1, 5'h10, 5'h01, 16'h0, 16'h8000, 0);
      txn(0, 5'h0A, 5'h15, 16'h1234, 16'h0, 1);
      txn(1, 5'h15, 5'h0A, 16'h0, 16'hA5C3, 1);
      // random mix
      for (int t = 0; t < 14; t++) begin
         txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
             16'($urandom), 1'($urandom));
      end
      chk(min_hi * 20 >= 160, "R1", "shortest MDC high ns", 64'(min_hi * 20), 64'd160);
      chk(min_lo * 20 >= 160, "R2", "shortest MDC low ns", 64'(min_lo * 20), 64'd160);
      chk(min_per * 20 >= 400, "R3", "shortest MDC period ns", 64'(min_per * 20), 64'd400);
      chk(chg_hi == 0, "R6", "data changes while MDC high", 64'(chg_hi), 64'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule